// File: doc/BRIEF.md
# Trigger Source Selection and Busy Veto

This block builds a trigger candidate from three independently enabled sources: an asynchronous external trigger line, a periodic pulser with a programmable period, and a random pulser whose firing probability is a programmable 32-bit fraction. Each cycle in which at least one enabled source fires yields a one-cycle candidate strobe.

A candidate becomes an accepted trigger only when the run is enabled and the combined busy (veto) signal is low. The combined busy is the OR of those busy inputs, after synchronization, that are not masked out. An accepted trigger is sent to a set of trigger outputs chosen by an output mask. The synchronized busy levels and the combined busy are visible as status outputs. A one-cycle clear request restarts both pulsers.

Top module: `trig_qualifier`

## Requirements
- R1: Each rising edge of `ext_trig_in`, with `src_ext_en` high, produces exactly one `cand_o` pulse, three clock edges after the edge is sampled. A level held high produces no further candidates.
- R2: With `src_fix_en` high, the periodic pulser fires once every P enabled cycles, where P = `fix_period`. A period of 0 behaves like a period of 1, so the pulser fires every cycle.
- R3: The random pulser fires in a cycle when its free-running 32-bit pseudo-random value is below `rnd_prob`. A probability of 0 never fires. A probability of all ones fires in nearly every cycle, and 2^31 fires in about half the cycles.
- R4: A source whose enable is low contributes no candidates. With all three enables low, `cand_o` stays low.
- R5: `busy_state` shows each `busy_in` bit after a two-flop synchronizer. `busy_any` is high exactly when some bit of `busy_state` is high while the matching `busy_mask` bit is 0 (1 = channel ignored).
- R6: `accept_o` is high in a cycle only if `cand_o` is high in that cycle and, one cycle earlier, `busy_any` was low and `run_en` was high. A candidate that arrives while busy is still reported on `cand_o`.
- R7: While `run_en` is low, candidates continue but `accept_o` stays low.
- R8: `trig_out` equals `out_mask` in a cycle where `accept_o` is high, and is zero otherwise.
- R9: A one-cycle `clear_req` resets the periodic pulser count to zero, so the next periodic firing comes a full period after the clear. It also reseeds the random pulser.
- R10: During and right after reset, `cand_o`, `accept_o`, `trig_out` and `busy_any` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_trig_in | input | 1 | Asynchronous external trigger line |
| busy_in | input | N_BUSY (14) | Asynchronous busy/veto inputs, one per channel |
| src_ext_en | input | 1 | Enable for the external trigger source |
| src_rnd_en | input | 1 | Enable for the random pulser |
| src_fix_en | input | 1 | Enable for the periodic pulser |
| run_en | input | 1 | Run enable; gates acceptance |
| clear_req | input | 1 | One-cycle pulser restart request |
| fix_period | input | CNT_W (32) | Periodic pulser period in clocks |
| rnd_prob | input | RND_W (32) | Random pulser firing threshold |
| busy_mask | input | N_BUSY (14) | 1 = ignore that busy channel |
| out_mask | input | N_OUT (8) | Trigger outputs that receive an accepted trigger |
| cand_o | output | 1 | Trigger candidate strobe |
| accept_o | output | 1 | Accepted trigger strobe |
| trig_out | output | N_OUT (8) | Masked accepted-trigger outputs |
| busy_state | output | N_BUSY (14) | Synchronized busy levels |
| busy_any | output | 1 | Combined unmasked busy |

## Verification
The hardest situation to reach is a clear that lands in the middle of a period. It only shows up as a missing pulse: a candidate that would have come without the clear does not come. The bench enables the periodic pulser with period 4 and lets two enabled cycles pass. It then pulses `clear_req` and lets three more cycles pass. Without the clear, a candidate would have appeared in that window, so an empty count shows the restart took effect. The busy veto is swept over all fourteen channels, each both unmasked and masked, under periodic candidates whose counts are known in advance.

// File: rtl/trigq_pkg.sv
package trigq_pkg;
   // Default Galois feedback mask for a 32-bit maximal-length sequence
   // (x^32 + x^22 + x^2 + x + 1, right-shifting form).
   localparam logic [31:0] POLY32_DEFAULT = 32'h8020_0003;
   localparam logic [31:0] SEED32_DEFAULT = 32'h1ACE_B00C;

   // Per-cycle source hits, used to form the candidate.
   typedef struct packed {
      logic ext;
      logic rnd;
      logic fix;
   } src_hit_t;

   function automatic logic any_hit(input src_hit_t h);
      return h.ext | h.rnd | h.fix;
   endfunction
endpackage

// File: rtl/trigq_sync.sv
module trigq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("trigq_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("trigq_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/trigq_fixed.sv
module trigq_fixed #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [CNT_W-1:0] period,
   output logic             pulse
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("trigq_fixed: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   // Period 0 is treated as period 1.
   assign lim   = (period == '0) ? '0 : period - CNT_W'(1);
   assign pulse = en && (cnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (clr || !en)   cnt <= '0;
      else if (cnt >= lim)   cnt <= '0;
      else                   cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/trigq_random.sv
module trigq_random #(
   parameter int             RND_W = 32,
   parameter logic [RND_W-1:0] POLY  = 32'h8020_0003,
   parameter logic [RND_W-1:0] SEED  = 32'h1ACE_B00C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [RND_W-1:0] prob,
   output logic             pulse
);
   generate
      if (RND_W < 8) begin : g_bad_width
         $error("trigq_random: RND_W must be at least 8");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("trigq_random: SEED must be nonzero");
      end
   endgenerate

   logic [RND_W-1:0] lfsr;
   logic [RND_W-1:0] lfsr_nx;

   assign lfsr_nx = lfsr[0] ? ((lfsr >> 1) ^ POLY) : (lfsr >> 1);
   assign pulse   = en && (lfsr < prob);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) lfsr <= SEED;
      else               lfsr <= lfsr_nx;
   end
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
   import trigq_pkg::*;
#(
   parameter int N_BUSY   = 14,
   parameter int N_OUT    = 8,
   parameter int CNT_W    = 32,
   parameter int RND_W    = 32,
   parameter int SYNC_LEN = 2,
   parameter bit EXT_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_trig_in,
   input  logic [N_BUSY-1:0] busy_in,
   input  logic              src_ext_en,
   input  logic              src_rnd_en,
   input  logic              src_fix_en,
   input  logic              run_en,
   input  logic              clear_req,
   input  logic [CNT_W-1:0]  fix_period,
   input  logic [RND_W-1:0]  rnd_prob,
   input  logic [N_BUSY-1:0] busy_mask,
   input  logic [N_OUT-1:0]  out_mask,
   output logic              cand_o,
   output logic              accept_o,
   output logic [N_OUT-1:0]  trig_out,
   output logic [N_BUSY-1:0] busy_state,
   output logic              busy_any
);
   generate
      if (N_BUSY < 1 || N_BUSY > 64) begin : g_bad_busy
         $error("trig_qualifier: N_BUSY out of range");
      end
      if (N_OUT < 1) begin : g_bad_out
         $error("trig_qualifier: N_OUT must be at least 1");
      end
   endgenerate

   // ---------------- input synchronization ----------------
   logic ext_sync;
   logic ext_evt;
   src_hit_t hit;
   logic fix_pulse;
   logic rnd_pulse;
   logic cand_q;
   logic acc_q;

   trigq_sync #(.W(1), .STAGES(SYNC_LEN)) u_ext_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_trig_in),
      .q     (ext_sync)
   );

   trigq_sync #(.W(N_BUSY), .STAGES(SYNC_LEN)) u_busy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (busy_in),
      .q     (busy_state)
   );

   // ---------------- external event: edge or level ----------------
   generate
      if (EXT_EDGE) begin : g_ext_edge
         logic ext_prev;
         always_ff @(posedge clk) begin
            if (!rst_n) ext_prev <= 1'b0;
            else        ext_prev <= ext_sync;
         end
         assign ext_evt = ext_sync & ~ext_prev;
      end else begin : g_ext_level
         assign ext_evt = ext_sync;
      end
   endgenerate

   // ---------------- pulsers ----------------
   trigq_fixed #(.CNT_W(CNT_W)) u_fixed (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clear_req),
      .en     (src_fix_en),
      .period (fix_period),
      .pulse  (fix_pulse)
   );

   trigq_random #(
      .RND_W (RND_W),
      .POLY  (RND_W'(POLY32_DEFAULT)),
      .SEED  (RND_W'(SEED32_DEFAULT))
   ) u_random (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clear_req),
      .en    (src_rnd_en),
      .prob  (rnd_prob),
      .pulse (rnd_pulse)
   );

   // ---------------- qualification ----------------
   assign hit.ext  = src_ext_en & ext_evt;
   assign hit.rnd  = rnd_pulse;
   assign hit.fix  = fix_pulse;
   assign busy_any = |(busy_state & ~busy_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand_q <= 1'b0;
         acc_q  <= 1'b0;
      end else begin
         cand_q <= any_hit(hit);
         acc_q  <= any_hit(hit) & ~busy_any & run_en;
      end
   end

   assign cand_o   = cand_q;
   assign accept_o = acc_q;
   assign trig_out = acc_q ? out_mask : '0;
endmodule

// File: rtl/trig_qualifier_checks.sv
module trig_qualifier_checks #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             src_ext_en,
   input logic             src_rnd_en,
   input logic             src_fix_en,
   input logic             run_en,
   input logic             clear_req,
   input logic [CNT_W-1:0] fix_period,
   input logic             cand_o,
   input logic             accept_o,
   input logic             busy_any
);
   // R6: no acceptance without a candidate
   a_r6_accept_needs_cand: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> cand_o);

   // R6: busy in one cycle vetoes the next strobe
   a_r6_busy_vetoes: assert property (@(posedge clk) disable iff (!rst_n)
      busy_any |=> !accept_o);

   // R7: run disabled blocks acceptance
   a_r7_run_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !accept_o);

   // R4: no enabled source, no candidate
   a_r4_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_ext_en && !src_rnd_en && !src_fix_en) |=> !cand_o);

   // R2: period 0 or 1 fires every cycle
   a_r2_unit_period_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (src_fix_en && fix_period <= CNT_W'(1)) |=> cand_o);

   // R9: directly after a clear, the periodic pulser cannot fire
   a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clear_req) && src_fix_en && !src_ext_en && !src_rnd_en
       && fix_period >= CNT_W'(2)) |=> !cand_o);
endmodule

bind trig_qualifier trig_qualifier_checks #(.CNT_W(CNT_W)) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_ext_en (src_ext_en),
   .src_rnd_en (src_rnd_en),
   .src_fix_en (src_fix_en),
   .run_en     (run_en),
   .clear_req  (clear_req),
   .fix_period (fix_period),
   .cand_o     (cand_o),
   .accept_o   (accept_o),
   .busy_any   (busy_any)
);

// File: tb/trig_qualifier_test.sv
module trig_qualifier_test;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 14;
   localparam int NO = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic ext_trig_in;
   logic [NB-1:0] busy_in;
   logic src_ext_en, src_rnd_en, src_fix_en, run_en, clear_req;
   logic [31:0] fix_period, rnd_prob;
   logic [NB-1:0] busy_mask;
   logic [NO-1:0] out_mask;
   logic cand_o, accept_o, busy_any;
   logic [NO-1:0] trig_out;
   logic [NB-1:0] busy_state;

   int checks = 0;
   int errors = 0;
   int n_cand, n_acc, n_out_bad;

   always #(CLK_PERIOD/2) clk = ~clk;

   trig_qualifier uut (
      .clk(clk), .rst_n(rst_n), .ext_trig_in(ext_trig_in), .busy_in(busy_in),
      .src_ext_en(src_ext_en), .src_rnd_en(src_rnd_en), .src_fix_en(src_fix_en),
      .run_en(run_en), .clear_req(clear_req), .fix_period(fix_period),
      .rnd_prob(rnd_prob), .busy_mask(busy_mask), .out_mask(out_mask),
      .cand_o(cand_o), .accept_o(accept_o), .trig_out(trig_out),
      .busy_state(busy_state), .busy_any(busy_any)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One observation per falling edge.
   task automatic observe(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (cand_o) n_cand++;
         if (accept_o) n_acc++;
         if (trig_out != (accept_o ? out_mask : '0)) n_out_bad++;
      end
   endtask

   task automatic clear_counts();
      n_cand = 0; n_acc = 0; n_out_bad = 0;
   endtask

   // Periodic pulser window: n enabled cycles then flush.
   task automatic fix_window(input int p, input int n);
      clear_counts();
      fix_period = p;
      src_fix_en = 1'b1;
      observe(n);
      src_fix_en = 1'b0;
      observe(4);
   endtask

   task automatic rnd_window(input logic [31:0] pr, input int n);
      clear_counts();
      rnd_prob = pr;
      src_rnd_en = 1'b1;
      observe(n);
      src_rnd_en = 1'b0;
      observe(4);
   endtask

   task automatic ext_pulses(input int k);
      clear_counts();
      for (int i = 0; i < k; i++) begin
         ext_trig_in = 1'b1;
         observe(3);
         ext_trig_in = 1'b0;
         observe(3);
      end
      observe(6);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ext_trig_in = 1'b0; busy_in = '0;
      src_ext_en = 1'b0; src_rnd_en = 1'b0; src_fix_en = 1'b0;
      run_en = 1'b1; clear_req = 1'b0; fix_period = 32'd4; rnd_prob = '0;
      busy_mask = '0; out_mask = 8'hA5;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!cand_o && !accept_o && trig_out == 0 && !busy_any, "R10", {cand_o, accept_o, busy_any}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!cand_o && !accept_o && trig_out == 0 && !busy_any, "R10 after release",
            {cand_o, accept_o, busy_any}, 0);

      // R2 + R8: period sweep, no busy, run on
      for (int p = 1; p <= 7; p++) begin
         fix_window(p, 42);
         check(n_cand == 42 / p, "R2 period sweep", n_cand, 42 / p);
         check(n_acc == 42 / p, "R6 accept equals cand", n_acc, 42 / p);
         check(n_out_bad == 0, "R8 trig_out", n_out_bad, 0);
      end
      fix_window(0, 10);
      check(n_cand == 10, "R2 period zero", n_cand, 10);

      // R8: other output masks
      out_mask = 8'h3C;
      fix_window(3, 12);
      check(n_out_bad == 0 && n_acc == 4, "R8 mask 3C", n_out_bad, 0);
      out_mask = 8'hFF;

      // R1: external edges; R4: disabled source
      src_ext_en = 1'b1;
      ext_pulses(5);
      check(n_cand == 5, "R1 one candidate per edge", n_cand, 5);
      clear_counts();
      ext_trig_in = 1'b1;
      observe(20);
      ext_trig_in = 1'b0;
      observe(6);
      check(n_cand == 1, "R1 held level", n_cand, 1);
      src_ext_en = 1'b0;
      ext_pulses(4);
      check(n_cand == 0, "R4 ext disabled", n_cand, 0);

      // R7: run disabled
      run_en = 1'b0;
      fix_window(2, 20);
      check(n_cand == 10, "R7 cand continues", n_cand, 10);
      check(n_acc == 0, "R7 no accept", n_acc, 0);
      run_en = 1'b1;

      // R5 + R6: busy sweep over every channel
      for (int ch = 0; ch < NB; ch++) begin
         busy_mask = '0;
         busy_in = NB'(1) << ch;
         observe(4);
         check(busy_state == (NB'(1) << ch), "R5 busy_state", busy_state, NB'(1) << ch);
         check(busy_any == 1'b1, "R5 busy_any unmasked", busy_any, 1);
         fix_window(3, 12);
         check(n_cand == 4 && n_acc == 0, "R6 veto while busy", n_acc, 0);
         busy_mask = ~(NB'(1) << ch);
         observe(1);
         check(busy_any == 1'b1, "R5 other channels masked", busy_any, 1);
         busy_mask = NB'(1) << ch;
         observe(1);
         check(busy_any == 1'b0, "R5 channel masked", busy_any, 0);
         fix_window(3, 12);
         check(n_acc == 4, "R6 masked busy accepts", n_acc, 4);
      end
      busy_in = '0;
      busy_mask = '0;
      observe(4);

      // R9: clear mid-period
      clear_counts();
      fix_period = 4;
      src_fix_en = 1'b1;
      observe(2);
      clear_req = 1'b1;
      observe(1);
      clear_req = 1'b0;
      observe(3);
      src_fix_en = 1'b0;
      observe(4);
      check(n_cand == 0, "R9 clear restarts period", n_cand, 0);

      // R3: random pulser
      rnd_window(32'd0, 400);
      check(n_cand == 0, "R3 zero probability", n_cand, 0);
      rnd_window(32'hFFFF_FFFF, 400);
      check(n_cand >= 399, "R3 full probability", n_cand, 400);
      rnd_window(32'h8000_0000, 400);
      check(n_cand >= 120 && n_cand <= 280, "R3 half probability", n_cand, 200);
      check(n_acc == n_cand, "R6 random accepted", n_acc, n_cand);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule